// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a direct-mapped cache and keeps a short run of lines that follow the most recent miss. When the cache misses on a line that is not at the front of the buffer, the buffer throws away what it holds and restarts. It then asks memory for the lines that come after the missed line, one request for each free slot. These prefetched lines stay in the buffer's own storage, so lines that are never used never displace anything in the cache. Each slot holds a line address (its tag), a flag that says whether the data has come back, and the data itself.

When the cache misses on the line at the front of the buffer and that line's data is present, the buffer hands the line over in the same cycle. It then retires that slot, which lets it request one more line in sequence. If the front line matches but its data is still on the way, the lookup is held off until the data arrives. Addresses are line addresses, so the next sequential line is the current address plus one, and the address wraps at the top of its range.

The lookup port and the memory request port both use valid/ready. A lookup is taken when `miss_valid` and `miss_ready` are both high. While `miss_ready` is low, the cache must hold `miss_valid` and `miss_addr` steady. A memory request is taken when `mem_req_valid` and `mem_req_ready` are both high. Memory returns data in the order the requests were issued, one line per `mem_rsp_valid` pulse. The buffer always accepts a response, because every request it issues either has a slot reserved for it or is known to be stale, so the response channel has no ready signal.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: After reset the buffer holds no lines: `mem_req_valid` is 0, `miss_ready` is 1 and `miss_hit` is 0.
- R2: A lookup on address A that does not match the front slot is accepted in the same cycle with `miss_hit`=0. From then on, requests go out for A+1, A+2, A+3 and so on, with the address wrapping modulo 2^ADDR_W.
- R3: A restart clears every slot. Once the DEPTH slots are allocated, no further request is issued until a slot is freed.
- R4: Responses fill the allocated slots in request order. A slot's line becomes usable only in the cycle after its response.
- R5: A lookup whose address equals the front slot's tag, when that slot's data is present, is accepted in the same cycle with `miss_hit`=1, and `miss_data` carries that line. The front slot is then retired.
- R6: A retired slot is reused for the next line in sequence, continuing from the last address requested.
- R7: A lookup that matches the front slot while its data is still missing keeps `miss_ready` low. `miss_ready` goes high in the cycle after that slot's response arrives.
- R8: Only the front slot is compared. A lookup that matches a later slot counts as a non-match and restarts the buffer.
- R9: Responses to requests issued before a restart, including a request accepted in the restart cycle itself, are discarded. The lines requested after the restart receive their own data.
- R10: At most 2*DEPTH requests are in flight at any time, counting both live and discarded ones.
- R11: A request that is not accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged until it is accepted or a restart occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Cache presents a missed line address |
| miss_ready | output | 1 | Lookup accepted this cycle |
| miss_addr | input | ADDR_W | Missed line address |
| miss_hit | output | 1 | Accepted lookup is served from the buffer |
| miss_data | output | DATA_W | Line data when `miss_hit` is 1 |
| mem_req_valid | output | 1 | Line fetch request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Line address to fetch |
| mem_rsp_valid | input | 1 | A line returns, in request order |
| mem_rsp_data | input | DATA_W | Returned line data |

## Verification
The assertions assume two things about the inputs. Memory never returns a response unless a request is outstanding. The cache holds its lookup steady while it is stalled. The memory model in the bench answers only from its own queue of accepted requests, in order, with random gaps, and it applies random back-pressure to requests. The lookup driver re-presents a stalled address until it is taken. Given those inputs, the assertions then rely on the design's own claims: stale responses are fully accounted for, and no slot is ever allocated into a full buffer.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_HIT     = 2'd1,
    LK_STALL   = 2'd2,
    LK_RESTART = 2'd3
  } lookup_e;
endpackage

// File: rtl/spb_store.sv
module spb_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_tag,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pop,
  output logic              head_valid,
  output logic              head_avail,
  output logic [ADDR_W-1:0] head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld, avl;
  logic [ADDR_W-1:0] tag  [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  logic [PTR_W-1:0]  hd, tl, fp;
  logic [CNT_W-1:0]  cnt;
  logic [DEPTH-1:0]  alloc_sel, fill_sel, pop_sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign alloc_sel[i] = alloc_en && !flush && (tl == PTR_W'(i));
    assign fill_sel[i]  = fill_en  && !flush && (fp == PTR_W'(i));
    assign pop_sel[i]   = pop      && !flush && (hd == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      avl <= '0;
      for (int i = 0; i < DEPTH; i++) tag[i] <= '0;
    end else if (flush) begin
      vld <= '0;
      avl <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_sel[i]) begin
          vld[i] <= 1'b1;
          avl[i] <= 1'b0;
          tag[i] <= alloc_tag;
        end else if (pop_sel[i]) begin
          vld[i] <= 1'b0;
          avl[i] <= 1'b0;
        end else if (fill_sel[i]) begin
          avl[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (fill_sel[i]) data[i] <= fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; fp <= '0; cnt <= '0;
    end else if (flush) begin
      hd <= '0; tl <= '0; fp <= '0; cnt <= '0;
    end else begin
      if (alloc_en) tl <= (tl == PTR_W'(DEPTH-1)) ? '0 : tl + 1'b1;
      if (fill_en)  fp <= (fp == PTR_W'(DEPTH-1)) ? '0 : fp + 1'b1;
      if (pop)      hd <= (hd == PTR_W'(DEPTH-1)) ? '0 : hd + 1'b1;
      cnt <= cnt + CNT_W'(alloc_en) - CNT_W'(pop);
    end
  end

  assign head_valid = vld[hd];
  assign head_avail = avl[hd];
  assign head_tag   = tag[hd];
  assign head_data  = data[hd];
  assign full       = (cnt == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !flush) |-> !full); // R3
  AST_FILL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |-> (vld[fp] && !avl[fp])); // R4
  AST_POP_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (head_valid && head_avail)); // R5
  AST_RESTART_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !head_valid)); // R8
endmodule

// File: rtl/spb_fetch.sv
module spb_fetch #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              full,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              alloc_en,
  output logic              fill_en
);
  localparam int MAX_OUT = 2 * DEPTH;
  localparam int OUT_W   = $clog2(MAX_OUT + 1);

  logic              active;
  logic [ADDR_W-1:0] nxt;
  logic [OUT_W-1:0]  pend, drop;
  logic [OUT_W:0]    inflight;
  logic              req_fire, live_rsp, stale_rsp;

  assign inflight      = {1'b0, pend} + {1'b0, drop};
  assign mem_req_valid = active && !full && (inflight < (OUT_W+1)'(MAX_OUT));
  assign mem_req_addr  = nxt;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign live_rsp      = mem_rsp_valid && (drop == '0);
  assign stale_rsp     = mem_rsp_valid && (drop != '0);
  assign alloc_en      = req_fire && !flush;
  assign fill_en       = live_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      nxt    <= '0;
      pend   <= '0;
      drop   <= '0;
    end else if (flush) begin
      active <= 1'b1;
      nxt    <= flush_addr;
      pend   <= '0;
      drop   <= drop - OUT_W'(stale_rsp) + pend - OUT_W'(live_rsp) + OUT_W'(req_fire);
    end else begin
      if (req_fire) nxt <= nxt + 1'b1;
      pend <= pend + OUT_W'(alloc_en) - OUT_W'(live_rsp);
      drop <= drop - OUT_W'(stale_rsp);
    end
  end

  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= (OUT_W+1)'(MAX_OUT)); // R10
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !flush) |=> (mem_req_addr == $past(mem_req_addr) + 1'b1)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !flush) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_RSP_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (inflight != '0)); // R9
endmodule

// File: rtl/stream_prefetch_buffer.sv
module stream_prefetch_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_hit,
  output logic [DATA_W-1:0] miss_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import spb_pkg::*;

  logic              head_valid, head_avail, full;
  logic [ADDR_W-1:0] head_tag;
  logic [DATA_W-1:0] head_data;
  logic              alloc_en, fill_en, head_match, pop, flush;
  lookup_e           lk;

  assign head_match = head_valid && (head_tag == miss_addr);

  always_comb begin
    if (!miss_valid)      lk = LK_IDLE;
    else if (!head_match) lk = LK_RESTART;
    else if (head_avail)  lk = LK_HIT;
    else                  lk = LK_STALL;
  end

  assign miss_ready = !head_match || head_avail;
  assign miss_hit   = head_match && head_avail;
  assign miss_data  = head_data;
  assign pop        = (lk == LK_HIT);
  assign flush      = (lk == LK_RESTART);

  spb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(alloc_en), .alloc_tag(mem_req_addr),
    .fill_en(fill_en), .fill_data(mem_rsp_data), .pop(pop),
    .head_valid(head_valid), .head_avail(head_avail),
    .head_tag(head_tag), .head_data(head_data), .full(full)
  );

  spb_fetch #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(miss_addr + 1'b1),
    .full(full), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .alloc_en(alloc_en), .fill_en(fill_en)
  );

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready && !mem_rsp_valid) |=> !miss_ready); // R7
  AST_HIT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_hit) |=> (!head_valid || head_tag != $past(head_tag) || DEPTH == 1)); // R5
endmodule

// File: tb/stream_prefetch_buffer_bench.sv
`timescale 1ns/1ps
module stream_prefetch_buffer_bench;
  localparam int DEPTH = 4, AW = 16, DW = 32;

  typedef struct { logic [AW-1:0] tag; bit avail; logic [DW-1:0] data; } ent_t;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic miss_ready, miss_hit, mem_req_valid;
  logic [DW-1:0] miss_data;
  logic [AW-1:0] mem_req_addr;

  int errors = 0, checks = 0;
  int rdy_pct = 100, rsp_pct = 100;
  ent_t ent_q[$];
  logic [AW-1:0] mem_q[$];
  int stale = 0;
  bit active = 0;
  logic [AW-1:0] nxt = '0;

  always #2.5 clk = ~clk;

  stream_prefetch_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_stream_prefetch_buffer (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_hit(miss_hit), .miss_data(miss_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DW-1:0] line_of(logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit mv, input logic [AW-1:0] ma, output bit acc);
    bit rsp, exp_rv, hm, exp_rdy, fire, fl, rf;
    @(negedge clk);
    miss_valid    = mv;
    miss_addr     = ma;
    mem_req_ready = ($urandom_range(99) < rdy_pct);
    rsp           = (mem_q.size() > 0) && ($urandom_range(99) < rsp_pct);
    mem_rsp_valid = rsp;
    mem_rsp_data  = rsp ? line_of(mem_q[0]) : '0;
    #1;
    exp_rv  = active && (ent_q.size() < DEPTH) && (mem_q.size() < 2*DEPTH);
    hm      = (ent_q.size() > 0) && (ent_q[0].tag == ma);
    exp_rdy = !hm || ent_q[0].avail;
    chk(DW'(mem_req_valid), DW'(exp_rv), "R3 R10 request valid");
    if (exp_rv) chk(DW'(mem_req_addr), DW'(nxt), "R2 R6 R11 request address");
    chk(DW'(miss_ready), DW'(exp_rdy), "R7 lookup ready");
    if (mv && exp_rdy) begin
      chk(DW'(miss_hit), DW'(hm), "R5 R8 lookup hit");
      if (hm) chk(miss_data, ent_q[0].data, "R4 R5 R9 line data");
    end
    fire = mv && exp_rdy;
    fl   = fire && !hm;
    rf   = exp_rv && mem_req_ready;
    acc  = fire;
    if (rsp) begin
      logic [DW-1:0] d;
      d = line_of(mem_q[0]);
      void'(mem_q.pop_front());
      if (stale > 0) stale--;
      else
        for (int k = 0; k < ent_q.size(); k++)
          if (!ent_q[k].avail) begin ent_q[k].avail = 1; ent_q[k].data = d; break; end
    end
    if (fire && hm) void'(ent_q.pop_front());
    if (rf) begin
      mem_q.push_back(nxt);
      if (!fl) begin ent_q.push_back('{tag: nxt, avail: 0, data: '0}); nxt = nxt + 1'b1; end
    end
    if (fl) begin
      ent_q.delete();
      stale  = mem_q.size();
      nxt    = ma + 1'b1;
      active = 1;
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a);
    bit acc;
    acc = 0;
    for (int n = 0; n < 400 && !acc; n++) step(1, a, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, '0, acc);
  endtask

  function automatic logic [AW-1:0] follow_addr();
    return (ent_q.size() > 0) ? ent_q[0].tag : nxt;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(DW'(mem_req_valid), 0, "R1 reset request valid");
    chk(DW'(miss_ready), 1, "R1 reset lookup ready");
    chk(DW'(miss_hit), 0, "R1 reset hit");
    rst_n = 1;
    idle(4);

    // R2 restart then in-order stream, fast memory
    lookup(16'h0100);
    idle(8);
    for (int i = 1; i <= 12; i++) lookup(16'h0100 + 16'(i));

    // R7 slow memory makes front-slot stalls
    rsp_pct = 25;
    for (int i = 0; i < 20; i++) lookup(follow_addr());

    // R8 match on a later slot restarts
    rsp_pct = 100;
    idle(10);
    lookup(follow_addr() + 16'd2);
    idle(6);
    for (int i = 0; i < 6; i++) lookup(follow_addr());

    // R9 R10 back-to-back restarts with slow memory
    rsp_pct = 8;
    for (int i = 0; i < 12; i++) lookup(16'h2000 + 16'(i * 16));
    for (int i = 0; i < 8; i++) lookup(follow_addr());

    // R2 address wrap
    rsp_pct = 70;
    lookup(16'hFFFD);
    for (int i = 0; i < 6; i++) lookup(follow_addr());

    // mixed traffic with back-pressure
    rdy_pct = 40; rsp_pct = 60;
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit acc;
      r = $urandom_range(99);
      if (r < 20) step(0, '0, acc);
      else if (r < 80) lookup(follow_addr());
      else lookup(16'($urandom_range(16'hFFFF)));
    end
    rdy_pct = 100; rsp_pct = 100;
    idle(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule